// File: doc/BRIEF.md
# Local SRAM Region Decoder and Source Selector

This block sits beside the core's memory pipeline. For every core access it decides whether the address falls inside one of two on-chip SRAM regions, and which source supplies the data: an SRAM region, the on-chip ROM or the cache. Each region has its own configuration register. The register holds a size-aligned base address, a valid flag and a flag that ties the region to either the instruction bus or the data bus. A region answers only accesses on the bus it is tied to. Debug references count as data-bus accesses. DMA requests never reach an SRAM region.

The decision is combinational and is made in the same cycle as the request, so one access can be resolved per clock. The outputs are a one-hot source select, a flag that keeps the cache from allocating or changing a line, and byte-lane enables for byte, 16-bit, 32-bit and line-sized accesses. A configuration write is captured at the clock edge and affects requests from the following cycle onward.

Top module: `lmem_region_sel`

## Requirements
- R1: While reset is held, and after it is released, both regions are invalid. No request selects an SRAM region until a region has been configured with its valid flag set.
- R2: A region matches when the address bits above the region size (default 4 KiB, bits 31:12) equal its base. The address bits below the region size do not affect the match.
- R3: A region whose bus flag is 0 matches only instruction fetches (kind 0). A region whose bus flag is 1 matches only data-bus accesses.
- R4: Debug references (kind 2) match exactly like data accesses (kind 1).
- R5: DMA requests (kind 3) never select an SRAM region, whatever the region registers hold.
- R6: With req_valid high, src_sel is one-hot with priority SRAM over ROM over cache. Bit 0 is region 0, bit 1 is region 1, bit 2 is ROM and bit 3 is cache. With req_valid low, src_sel is zero.
- R7: When both regions match the same access, region 0 is selected.
- R8: cache_inhibit is high exactly when a valid request is served by SRAM or ROM.
- R9: For a 32-bit bus, lane_en is computed from req_size and addr[1:0]. A byte (size 0) enables lane addr[1:0]. A 16-bit access (size 1) enables lanes 1:0 when addr[1]=0 and lanes 3:2 when addr[1]=1. A 32-bit access (size 2) and a line access (size 3) enable all four lanes. With req_valid low, lane_en is zero.
- R10: A configuration write loads the register selected by cfg_sel at the clock edge. A request in the same cycle as the write is decoded with the old contents. A request in the next cycle is decoded with the new contents.
- R11: A region whose valid flag is 0 never matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Index of the region register to write |
| cfg_base | input | 20 | Region base, address bits 31:12 |
| cfg_valid | input | 1 | Region valid flag to write |
| cfg_on_dbus | input | 1 | Bus flag to write: 0 instruction bus, 1 data bus |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 fetch, 1 data, 2 debug, 3 DMA |
| req_addr | input | 32 | Access byte address |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 line |
| rom_hit | input | 1 | The ROM decoder reports a hit for this access |
| src_sel | output | 4 | One-hot source: sram0, sram1, rom, cache |
| cache_inhibit | output | 1 | Keep the cache from allocating or changing a line |
| lane_en | output | 4 | Byte-lane enables |

## Verification
Two of the block's functions can act in the same cycle: a configuration write and a request that decodes against the register being written. The bench provokes this by retiring or moving a region in exactly the cycle a request targets it. It expects the old decode in that cycle and the new decode in the next. The second meeting point is an access that several sources claim at once: both regions plus the ROM. That case is judged by the fixed priority, and on every clock all three outputs are compared with a behavioural reference model.

// File: rtl/lmem_pkg.sv
// Shared encodings for the local SRAM region selector.
// Assumes the access-kind and size codes below are fixed by the core pipeline.
package lmem_pkg;

    typedef enum logic [1:0] {
        KIND_IFETCH = 2'd0,
        KIND_DATA   = 2'd1,
        KIND_DEBUG  = 2'd2,
        KIND_DMA    = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LINE = 2'd3
    } acc_size_e;

endpackage

// File: rtl/lmem_cfg_regs.sv
// Holds the region configuration registers.
// Assumes one write port; a write is visible the cycle after its strobe.
module lmem_cfg_regs #(
    parameter int N_REGION = 2,
    parameter int BASE_W   = 20,
    parameter int SEL_W    = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [SEL_W-1:0]                 sel,
    input  logic [BASE_W-1:0]                base_in,
    input  logic                             valid_in,
    input  logic                             dbus_in,
    output logic [N_REGION-1:0][BASE_W-1:0]  base_o,
    output logic [N_REGION-1:0]              valid_o,
    output logic [N_REGION-1:0]              dbus_o
);

    for (genvar r = 0; r < N_REGION; r++) begin : g_reg
        // Purpose: clear one region on reset; load it when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[r]  <= '0;
                valid_o[r] <= 1'b0;
                dbus_o[r]  <= 1'b0;
            end else if (we && (int'(sel) == r)) begin
                base_o[r]  <= base_in;
                valid_o[r] <= valid_in;
                dbus_o[r]  <= dbus_in;
            end
        end
    end

endmodule

// File: rtl/lmem_region_match.sv
// Decides whether one region claims the current access.
// Assumes the base is size-aligned, so only the upper address bits are compared.
module lmem_region_match #(
    parameter int BASE_W = 20
) (
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [BASE_W-1:0] addr_hi,
    input  logic [BASE_W-1:0] base,
    input  logic              valid,
    input  logic              on_dbus,
    output logic              hit
);
    import lmem_pkg::*;

    logic bus_ok;

    // Purpose: check that the access travels on the bus this region is tied to.
    always_comb begin
        unique case (acc_kind_e'(req_kind))
            KIND_IFETCH: bus_ok = !on_dbus;
            KIND_DATA,
            KIND_DEBUG:  bus_ok = on_dbus;
            default:     bus_ok = 1'b0;
        endcase
    end

    // Purpose: combine the request, valid flag, bus check and address compare.
    always_comb begin
        hit = req_valid && valid && bus_ok && (addr_hi == base);
    end

endmodule

// File: rtl/lmem_src_arbiter.sv
// Turns region hits and the ROM hit into a one-hot source select.
// Assumes the lower region index wins; the cache is the fallback.
module lmem_src_arbiter #(
    parameter int N_REGION = 2,
    parameter int SRC_W    = N_REGION + 2
) (
    input  logic                req_valid,
    input  logic [N_REGION-1:0] hits,
    input  logic                rom_hit,
    output logic [SRC_W-1:0]    src_sel,
    output logic                cache_inhibit
);
    localparam int ROM_IDX   = N_REGION;
    localparam int CACHE_IDX = N_REGION + 1;

    logic taken;

    // Purpose: give the grant to the first claimant in SRAM, ROM, cache order.
    always_comb begin
        src_sel = '0;
        taken   = 1'b0;
        if (req_valid) begin
            for (int r = 0; r < N_REGION; r++) begin
                if (hits[r] && !taken) begin
                    src_sel[r] = 1'b1;
                    taken      = 1'b1;
                end
            end
            if (!taken && rom_hit) begin
                src_sel[ROM_IDX] = 1'b1;
                taken            = 1'b1;
            end
            if (!taken) begin
                src_sel[CACHE_IDX] = 1'b1;
            end
        end
    end

    // Purpose: keep the cache untouched whenever a local source serves the access.
    always_comb begin
        cache_inhibit = req_valid && ((|hits) || rom_hit);
    end

endmodule

// File: rtl/lmem_lane_gen.sv
// Computes byte-lane enables from the access size and low address bits.
// Assumes naturally aligned accesses; line accesses enable every lane.
module lmem_lane_gen #(
    parameter int LANES     = 4,
    parameter int LANE_LOG2 = $clog2(LANES)
) (
    input  logic                 req_valid,
    input  logic [1:0]           req_size,
    input  logic [LANE_LOG2-1:0] offset,
    output logic [LANES-1:0]     lane_en
);
    import lmem_pkg::*;

    int shift;

    // Purpose: pick the lanes that share the access's aligned block.
    always_comb begin
        case (acc_size_e'(req_size))
            SZ_BYTE: shift = 0;
            SZ_HALF: shift = 1;
            SZ_WORD: shift = 2;
            default: shift = LANE_LOG2;
        endcase
        if (shift > LANE_LOG2) shift = LANE_LOG2;
        for (int i = 0; i < LANES; i++) begin
            lane_en[i] = req_valid && ((i >> shift) == (int'(offset) >> shift));
        end
    end

endmodule

// File: rtl/lmem_region_sel.sv
// Top: decodes each core access against the local SRAM regions and selects
// the data source, the cache-inhibit flag and the byte lanes in the same cycle.
// Assumes region bases are aligned to 2**REGION_LOG2 bytes.
module lmem_region_sel #(
    parameter int ADDR_W      = 32,
    parameter int REGION_LOG2 = 12,
    parameter int N_REGION    = 2,
    parameter int LANES       = 4,
    parameter int BASE_W      = ADDR_W - REGION_LOG2,
    parameter int SEL_W       = (N_REGION > 1) ? $clog2(N_REGION) : 1,
    parameter int SRC_W       = N_REGION + 2,
    parameter int LANE_LOG2   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic              cfg_valid,
    input  logic              cfg_on_dbus,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              rom_hit,
    output logic [SRC_W-1:0]  src_sel,
    output logic              cache_inhibit,
    output logic [LANES-1:0]  lane_en
);

    logic [N_REGION-1:0][BASE_W-1:0] reg_base;
    logic [N_REGION-1:0]             reg_valid;
    logic [N_REGION-1:0]             reg_dbus;
    logic [N_REGION-1:0]             hits;

    lmem_cfg_regs #(
        .N_REGION (N_REGION),
        .BASE_W   (BASE_W),
        .SEL_W    (SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .base_in  (cfg_base),
        .valid_in (cfg_valid),
        .dbus_in  (cfg_on_dbus),
        .base_o   (reg_base),
        .valid_o  (reg_valid),
        .dbus_o   (reg_dbus)
    );

    for (genvar r = 0; r < N_REGION; r++) begin : g_match
        lmem_region_match #(
            .BASE_W (BASE_W)
        ) u_match (
            .req_valid (req_valid),
            .req_kind  (req_kind),
            .addr_hi   (req_addr[ADDR_W-1:REGION_LOG2]),
            .base      (reg_base[r]),
            .valid     (reg_valid[r]),
            .on_dbus   (reg_dbus[r]),
            .hit       (hits[r])
        );
    end

    lmem_src_arbiter #(
        .N_REGION (N_REGION),
        .SRC_W    (SRC_W)
    ) u_arb (
        .req_valid     (req_valid),
        .hits          (hits),
        .rom_hit       (rom_hit),
        .src_sel       (src_sel),
        .cache_inhibit (cache_inhibit)
    );

    lmem_lane_gen #(
        .LANES     (LANES),
        .LANE_LOG2 (LANE_LOG2)
    ) u_lanes (
        .req_valid (req_valid),
        .req_size  (req_size),
        .offset    (req_addr[LANE_LOG2-1:0]),
        .lane_en   (lane_en)
    );

endmodule

// File: rtl/lmem_region_sel_chk.sv
// Checker for the region selector, bound to every instance of the top.
// Assumes the last two src_sel bits are ROM and cache.
module lmem_region_sel_chk #(
    parameter int N_REGION = 2,
    parameter int LANES    = 4,
    parameter int SRC_W    = N_REGION + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic             rom_hit,
    input logic [SRC_W-1:0] src_sel,
    input logic             cache_inhibit,
    input logic [LANES-1:0] lane_en
);

    assert_onehot_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones(src_sel) == 1);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (src_sel == '0 && !cache_inhibit && lane_en == '0));

    assert_dma_no_sram_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |-> (src_sel[N_REGION-1:0] == '0));

    assert_rom_beats_cache_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rom_hit) |-> !src_sel[SRC_W-1]);

    assert_inhibit_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (cache_inhibit == !src_sel[SRC_W-1]));

    assert_lanes_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (lane_en != '0));

endmodule

bind lmem_region_sel lmem_region_sel_chk #(
    .N_REGION (N_REGION),
    .LANES    (LANES),
    .SRC_W    (SRC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .rom_hit       (rom_hit),
    .src_sel       (src_sel),
    .cache_inhibit (cache_inhibit),
    .lane_en       (lane_en)
);

// File: tb/lmem_region_sel_tb.sv
`timescale 1ns/1ps
module lmem_region_sel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [19:0] cfg_base = '0;
    logic        cfg_valid = 1'b0;
    logic        cfg_on_dbus = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        rom_hit = 1'b0;
    logic [3:0]  src_sel;
    logic        cache_inhibit;
    logic [3:0]  lane_en;

    int checks = 0;
    int errors = 0;

    // Reference state: region registers as the requirements describe them.
    int m_base [2];
    bit m_valid [2];
    bit m_dbus [2];

    always #5 clk = ~clk;

    lmem_region_sel u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_base (cfg_base),
        .cfg_valid (cfg_valid), .cfg_on_dbus (cfg_on_dbus),
        .req_valid (req_valid), .req_kind (req_kind), .req_addr (req_addr),
        .req_size (req_size), .rom_hit (rom_hit),
        .src_sel (src_sel), .cache_inhibit (cache_inhibit), .lane_en (lane_en)
    );

    // Behavioural expectation for the inputs of the current cycle.
    function automatic void expect_out(output logic [3:0] e_sel, output logic e_inh,
                                       output logic [3:0] e_lane);
        int src;
        int off;
        src = 3;
        if (req_valid && rom_hit) src = 2;
        for (int r = 1; r >= 0; r--) begin
            bit bus_ok;
            bus_ok = m_dbus[r] ? (req_kind == 1 || req_kind == 2) : (req_kind == 0);
            if (req_valid && m_valid[r] && bus_ok && int'(req_addr >> 12) == m_base[r])
                src = r;
        end
        e_sel = req_valid ? 4'(1 << src) : 4'h0;
        e_inh = req_valid && src != 3;
        off = int'(req_addr % 4);
        if (!req_valid) e_lane = 4'h0;
        else if (req_size == 0) e_lane = 4'(1 << off);
        else if (req_size == 1) e_lane = (off >= 2) ? 4'hC : 4'h3;
        else e_lane = 4'hF;
    endfunction

    // One cycle: drive after the falling edge, compare, then commit writes to the model.
    task automatic cyc(input bit we, input int sel, input int base, input bit v, input bit d,
                       input bit rv, input int kind, input logic [31:0] addr,
                       input int size, input bit rom, input string tag);
        logic [3:0] e_sel;
        logic [3:0] e_lane;
        logic e_inh;
        @(negedge clk);
        cfg_we = we; cfg_sel = 1'(sel); cfg_base = 20'(base);
        cfg_valid = v; cfg_on_dbus = d;
        req_valid = rv; req_kind = 2'(kind); req_addr = addr;
        req_size = 2'(size); rom_hit = rom;
        #2;
        expect_out(e_sel, e_inh, e_lane);
        checks++;
        if (src_sel !== e_sel || cache_inhibit !== e_inh || lane_en !== e_lane) begin
            errors++;
            $display("FAIL %s: actual sel=%h inh=%b lane=%h expected sel=%h inh=%b lane=%h",
                     tag, src_sel, cache_inhibit, lane_en, e_sel, e_inh, e_lane);
        end
        if (we && rst_n) begin
            m_base[sel] = base; m_valid[sel] = v; m_dbus[sel] = d;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < 2; r++) begin
            m_base[r] = 0; m_valid[r] = 0; m_dbus[r] = 0;
        end
        // R1: held in reset, a write is dropped and nothing hits
        cyc(1, 0, 0, 1, 0, 1, 0, 32'h0000_0010, 2, 0, "R1 reset write ignored");
        cyc(0, 0, 0, 0, 0, 1, 1, 32'h0000_0000, 2, 0, "R1 reset");
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 1, 0, 32'h0000_0010, 2, 0, "R1 after reset");

        // Configure region 0 on the fetch bus and region 1 on the data bus.
        cyc(1, 0, 32'h20000, 1, 0, 0, 0, 0, 0, 0, "R6 idle");
        cyc(1, 1, 32'h20001, 1, 1, 0, 0, 0, 0, 0, "R6 idle");
        cyc(0, 0, 0, 0, 0, 1, 0, 32'h2000_0004, 2, 1, "R2 R3 fetch hits region 0");
        cyc(0, 0, 0, 0, 0, 1, 0, 32'h2000_0FFE, 1, 0, "R2 low bits ignored, R9 half hi");
        cyc(0, 0, 0, 0, 0, 1, 1, 32'h2000_0004, 2, 0, "R3 data misses fetch region");
        cyc(0, 0, 0, 0, 0, 1, 1, 32'h2000_1FFF, 0, 1, "R3 data hits region 1, R9 byte");
        cyc(0, 0, 0, 0, 0, 1, 0, 32'h2000_1000, 2, 0, "R3 fetch misses data region");
        cyc(0, 0, 0, 0, 0, 1, 2, 32'h2000_1002, 1, 0, "R4 debug as data, R9 half");
        cyc(0, 0, 0, 0, 0, 1, 3, 32'h2000_1000, 3, 0, "R5 DMA to cache, R9 line");
        cyc(0, 0, 0, 0, 0, 1, 3, 32'h2000_1000, 2, 1, "R5 DMA to ROM");
        cyc(0, 0, 0, 0, 0, 1, 0, 32'h3000_0001, 0, 1, "R6 R8 ROM over cache");
        cyc(0, 0, 0, 0, 0, 1, 1, 32'h2000_2000, 0, 0, "R2 above region, R8 cache");

        // R7: move region 1 onto region 0's window, fetch bus
        cyc(1, 1, 32'h20000, 1, 0, 0, 0, 0, 0, 0, "R6 idle");
        cyc(0, 0, 0, 0, 0, 1, 0, 32'h2000_0100, 2, 1, "R7 region 0 wins overlap");

        // R10: retire region 0 in the same cycle as a fetch into it
        cyc(1, 0, 32'h20000, 0, 0, 1, 0, 32'h2000_0200, 2, 0, "R10 old value same cycle");
        cyc(0, 0, 0, 0, 0, 1, 0, 32'h2000_0200, 2, 0, "R10 R11 new value next cycle");
        cyc(1, 1, 32'h20000, 0, 1, 1, 0, 32'h2000_0300, 2, 0, "R10 old region 1 same cycle");
        cyc(0, 0, 0, 0, 0, 1, 1, 32'h2000_0300, 2, 0, "R11 invalid region never hits");

        // Mixed traffic, compared with the model on every clock.
        for (int i = 0; i < 400; i++) begin
            bit we;
            int base;
            int hi;
            we = ($urandom % 6) == 0;
            base = 32'h40000 + int'($urandom % 3);
            hi = 32'h40000 + int'($urandom % 4);
            cyc(we, int'($urandom % 2), base, bit'($urandom % 4 != 0), bit'($urandom % 2),
                bit'($urandom % 8 != 0), int'($urandom % 4),
                (32'(hi) << 12) | 32'($urandom % 4096), int'($urandom % 4),
                bit'($urandom % 3 == 0), "R6 R3 R7 R10 mixed traffic");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule